// File: doc/BRIEF.md
# Priority I/O Pin Crossbar

This block decides which on-chip digital peripheral signal drives each pin of an 8-pin general-purpose port. It takes a per-signal enable vector for 13 peripheral signals, which have a fixed priority, and an 8-bit skip mask that software uses to keep pins free for GPIO or analog use. The two UART signals always sit on fixed pins. Every other enabled signal goes, in priority order, to the lowest pin that is still free.

Each pin gets a 4-bit code that names the signal routed to it, or zero for GPIO. Each signal gets the index of the pin it was placed on, with a valid flag. An enabled signal that finds no free pin loses its valid flag and displaces nothing. The result can be registered, which is the default, so the port mux is fed from flops.

Signal indices, from highest to lowest priority: 0 uart_tx, 1 uart_rx, 2 i2c_data, 3 i2c_clock, 4 cmp_sync, 5 cmp_async, 6 clk_out, 7 pca_ch0, 8 pca_ch1, 9 pca_ch2, 10 pca_ext_clk, 11 tmr0_in, 12 tmr1_in.

Top module: `xbar_crossbar`

## Requirements
- R1: While rst_ni is low, and after it rises until the first capture, every pin code reads 0, and all sig_vld_o and sig_pin_o bits read 0.
- R2: If sig_en_i[0] is set, pin 4 carries code 1 and signal 0 reports pin 4 as valid. If sig_en_i[1] is set, pin 5 carries code 2 and signal 1 reports pin 5 as valid. Both hold whatever pin_skip_i holds.
- R3: If either sig_en_i[0] or sig_en_i[1] is set, pins 4 and 5 are both kept out of the sequential placement. If both bits are clear, pins 4 and 5 are ordinary candidates.
- R4: Signals 2 to 12 are placed in index order. Each enabled one takes the lowest-numbered pin that is not skipped, not reserved and not already given to an earlier signal, so placed pins rise with signal index.
- R5: A pin whose pin_skip_i bit is set receives no signal from indices 2 to 12, and its code stays 0 unless R2 places a UART signal there.
- R6: The code for pin p sits at pin_sel_o[4p+3:4p] and equals the signal index plus 1 (0 means GPIO). The pin index for signal i sits at sig_pin_o[3i+2:3i], with its valid flag at sig_vld_o[i].
- R7: A disabled signal has sig_vld_o and its sig_pin_o field at 0 and claims no pin.
- R8: An enabled signal that finds no free pin gets sig_vld_o at 0 and a pin field of 0. Every higher-priority placement stays as it was.
- R9: With REG_OUT=1, the outputs show the inputs sampled at the previous rising clk_i edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sig_en_i | input | 13 | Per-signal enable, index = priority |
| pin_skip_i | input | 8 | Pins kept out of sequential placement |
| pin_sel_o | output | 32 | Per-pin 4-bit routed signal code |
| sig_pin_o | output | 39 | Per-signal 3-bit pin index |
| sig_vld_o | output | 13 | Per-signal placement valid |

## Verification
A wrong busy vector in the placement chain shows at the ports on the next clock edge. It appears as a signal moved to a higher pin than the lowest free one, as two signals claiming one pin, or as an overflow flagged too early or too late. The pin codes and the per-signal fields describe the same mapping from two sides, so they are cross-checked against each other in every cycle. Each cycle is also compared with a free-pin queue model, under directed corner cases (full enable, skip patterns, UART on and off, overflow) and under random enable and skip combinations.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned XBAR_N_SIG  = 13;
  localparam int unsigned XBAR_N_PIN  = 8;
  localparam int unsigned XBAR_TX_PIN = 4;
  localparam int unsigned XBAR_RX_PIN = 5;

  typedef enum logic [3:0] {
    SIG_UART_TX   = 4'd0,
    SIG_UART_RX   = 4'd1,
    SIG_I2C_DATA  = 4'd2,
    SIG_I2C_CLOCK = 4'd3,
    SIG_CMP_SYNC  = 4'd4,
    SIG_CMP_ASYNC = 4'd5,
    SIG_CLK_OUT   = 4'd6,
    SIG_PCA_CH0   = 4'd7,
    SIG_PCA_CH1   = 4'd8,
    SIG_PCA_CH2   = 4'd9,
    SIG_PCA_ECLK  = 4'd10,
    SIG_TMR0_IN   = 4'd11,
    SIG_TMR1_IN   = 4'd12
  } sig_id_e;

  // First index placed by the sequential walk.
  localparam int unsigned XBAR_FIRST_SEQ = 2;
endpackage

// File: rtl/xbar_lowest_free.sv
module xbar_lowest_free #(
  parameter int unsigned N_PIN = 8
) (
  input  logic [N_PIN-1:0] busy_i,
  output logic [N_PIN-1:0] grant_o
);
  // Lowest clear bit: ~b & (b+1); all-busy wraps to zero.
  logic [N_PIN-1:0] inc;
  assign inc     = busy_i + N_PIN'(1);
  assign grant_o = ~busy_i & inc;
endmodule

// File: rtl/xbar_oh2bin.sv
module xbar_oh2bin #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] oh_i,
  output logic [W-1:0] bin_o
);
  always_comb begin
    bin_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_i[i]) bin_o = bin_o | W'(i);
    end
  end
endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar
  import xbar_pkg::*;
#(
  parameter int unsigned N_SIG   = XBAR_N_SIG,
  parameter int unsigned N_PIN   = XBAR_N_PIN,
  parameter int unsigned TX_PIN  = XBAR_TX_PIN,
  parameter int unsigned RX_PIN  = XBAR_RX_PIN,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PIN_W  = $clog2(N_PIN),
  localparam int unsigned SEL_W  = $clog2(N_SIG + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SIG-1:0]       sig_en_i,
  input  logic [N_PIN-1:0]       pin_skip_i,
  output logic [N_PIN*SEL_W-1:0] pin_sel_o,
  output logic [N_SIG*PIN_W-1:0] sig_pin_o,
  output logic [N_SIG-1:0]       sig_vld_o
);
  localparam int unsigned FS    = XBAR_FIRST_SEQ;
  localparam int unsigned N_SEQ = N_SIG - FS;

  logic [N_PIN-1:0] uart_mask;
  logic             uart_on;
  logic [N_PIN-1:0] grant [N_SIG];
  logic [N_PIN-1:0] busy  [N_SEQ+1];

  logic [N_PIN*SEL_W-1:0] sel_d;
  logic [N_SIG*PIN_W-1:0] pin_d;
  logic [N_SIG-1:0]       vld_d;

  assign uart_mask = (N_PIN'(1) << TX_PIN) | (N_PIN'(1) << RX_PIN);
  assign uart_on   = sig_en_i[SIG_UART_TX] | sig_en_i[SIG_UART_RX];

  // Fixed-location pair.
  assign grant[0] = sig_en_i[0] ? (N_PIN'(1) << TX_PIN) : '0;
  assign grant[1] = sig_en_i[1] ? (N_PIN'(1) << RX_PIN) : '0;

  // Reserved UART pins are preloaded as busy, just like skipped pins.
  assign busy[0] = pin_skip_i | (uart_on ? uart_mask : '0);

  for (genvar k = 0; k < N_SEQ; k++) begin : g_walk
    logic [N_PIN-1:0] cand;
    xbar_lowest_free #(.N_PIN(N_PIN)) u_free (
      .busy_i (busy[k]),
      .grant_o(cand)
    );
    assign grant[FS+k] = sig_en_i[FS+k] ? cand : '0;
    assign busy[k+1]   = busy[k] | grant[FS+k];
  end

  for (genvar i = 0; i < N_SIG; i++) begin : g_sig
    logic [PIN_W-1:0] idx;
    xbar_oh2bin #(.N(N_PIN)) u_enc (
      .oh_i (grant[i]),
      .bin_o(idx)
    );
    assign vld_d[i]                   = |grant[i];
    assign pin_d[i*PIN_W +: PIN_W]    = idx;
  end

  always_comb begin
    sel_d = '0;
    for (int p = 0; p < N_PIN; p++) begin
      for (int i = 0; i < N_SIG; i++) begin
        if (grant[i][p]) sel_d[p*SEL_W +: SEL_W] = sel_d[p*SEL_W +: SEL_W] | SEL_W'(i + 1);
      end
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pin_sel_o <= '0;
        sig_pin_o <= '0;
        sig_vld_o <= '0;
      end else begin
        pin_sel_o <= sel_d;
        sig_pin_o <= pin_d;
        sig_vld_o <= vld_d;
      end
    end
  end else begin : g_comb
    assign pin_sel_o = sel_d;
    assign sig_pin_o = pin_d;
    assign sig_vld_o = vld_d;
  end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int unsigned N_SIG   = 13,
  parameter int unsigned N_PIN   = 8,
  parameter int unsigned TX_PIN  = 4,
  parameter int unsigned RX_PIN  = 5,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned PIN_W  = $clog2(N_PIN),
  localparam int unsigned SEL_W  = $clog2(N_SIG + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SIG-1:0]       sig_en_i,
  input logic [N_PIN-1:0]       pin_skip_i,
  input logic [N_PIN*SEL_W-1:0] pin_sel_o,
  input logic [N_SIG*PIN_W-1:0] sig_pin_o,
  input logic [N_SIG-1:0]       sig_vld_o
);
  // Inputs aligned with the outputs they produced.
  logic [N_SIG-1:0] en_q;
  logic [N_PIN-1:0] skip_q;
  logic [N_SIG-1:0] en_a;
  logic [N_PIN-1:0] skip_a;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      skip_q <= '0;
    end else begin
      en_q   <= sig_en_i;
      skip_q <= pin_skip_i;
    end
  end
  assign en_a   = REG_OUT ? en_q : sig_en_i;
  assign skip_a = REG_OUT ? skip_q : pin_skip_i;

  a_r2_tx_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_a[0] |-> (pin_sel_o[TX_PIN*SEL_W +: SEL_W] == SEL_W'(1)) && sig_vld_o[0]
                && (sig_pin_o[0 +: PIN_W] == PIN_W'(TX_PIN)));
  a_r2_rx_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_a[1] |-> (pin_sel_o[RX_PIN*SEL_W +: SEL_W] == SEL_W'(2)) && sig_vld_o[1]
                && (sig_pin_o[PIN_W +: PIN_W] == PIN_W'(RX_PIN)));

  for (genvar i = 0; i < N_SIG; i++) begin : g_sig
    a_r7_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_a[i] |-> !sig_vld_o[i] && (sig_pin_o[i*PIN_W +: PIN_W] == '0));
    a_r6_pin_code_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sig_vld_o[i] |-> (pin_sel_o[sig_pin_o[i*PIN_W +: PIN_W]*SEL_W +: SEL_W] == SEL_W'(i + 1)));
    if (i >= 2) begin : g_seq
      a_r5_skip_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sig_vld_o[i] |-> !skip_a[sig_pin_o[i*PIN_W +: PIN_W]]);
      a_r3_uart_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sig_vld_o[i] && (en_a[0] || en_a[1])) |->
          (sig_pin_o[i*PIN_W +: PIN_W] != PIN_W'(TX_PIN)) &&
          (sig_pin_o[i*PIN_W +: PIN_W] != PIN_W'(RX_PIN)));
      for (genvar j = 2; j < i; j++) begin : g_ord
        a_r4_rising_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (sig_vld_o[i] && sig_vld_o[j]) |->
            (sig_pin_o[j*PIN_W +: PIN_W] < sig_pin_o[i*PIN_W +: PIN_W]));
      end
      if (i + 1 < N_SIG) begin : g_ovf
        a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (en_a[i] && !sig_vld_o[i]) |-> !sig_vld_o[i+1]);
      end
    end
  end
endmodule

bind xbar_crossbar xbar_checker #(
  .N_SIG(N_SIG), .N_PIN(N_PIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/xbar_crossbar_tb.sv
module xbar_crossbar_tb_top;
  localparam int NS = 13;
  localparam int NP = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] sig_en_i = '0;
  logic [NP-1:0] pin_skip_i = '0;
  logic [NP*4-1:0] pin_sel_o;
  logic [NS*3-1:0] sig_pin_o;
  logic [NS-1:0]   sig_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  xbar_crossbar dut_i (
    .clk_i, .rst_ni, .sig_en_i, .pin_skip_i, .pin_sel_o, .sig_pin_o, .sig_vld_o
  );

  always #5 clk_i = ~clk_i;

  int exp_sel [NP];
  int exp_pin [NS];
  bit exp_vld [NS];

  // Free-pin queue model.
  task automatic model(input logic [NS-1:0] en, input logic [NP-1:0] skip);
    int q[$];
    bit uart;
    uart = en[0] || en[1];
    for (int p = 0; p < NP; p++) exp_sel[p] = 0;
    for (int s = 0; s < NS; s++) begin exp_pin[s] = 0; exp_vld[s] = 0; end
    for (int p = 0; p < NP; p++)
      if (!skip[p] && !(uart && (p == 4 || p == 5))) q.push_back(p);
    if (en[0]) begin exp_pin[0] = 4; exp_vld[0] = 1; exp_sel[4] = 1; end
    if (en[1]) begin exp_pin[1] = 5; exp_vld[1] = 1; exp_sel[5] = 2; end
    for (int s = 2; s < NS; s++) begin
      if (en[s] && q.size() > 0) begin
        int p;
        p = q.pop_front();
        exp_pin[s] = p; exp_vld[s] = 1; exp_sel[p] = s + 1;
      end
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp, input string what, input int idx);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s[%0d] actual %0d expected %0d", tag, what, idx, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < NP; p++) chk(tag, int'(pin_sel_o[p*4 +: 4]), exp_sel[p], "pin_sel", p);
    for (int s = 0; s < NS; s++) begin
      chk(tag, int'(sig_vld_o[s]), int'(exp_vld[s]), "sig_vld", s);
      chk(tag, int'(sig_pin_o[s*3 +: 3]), exp_pin[s], "sig_pin", s);
    end
  endtask

  // Apply at negedge, check result one cycle later at the next negedge.
  task automatic step(input string tag, input logic [NS-1:0] en, input logic [NP-1:0] skip);
    logic [NS-1:0] pe;
    logic [NP-1:0] ps;
    pe = sig_en_i; ps = pin_skip_i;
    sig_en_i = en; pin_skip_i = skip;
    #1;
    model(pe, ps);
    compare("R9");
    @(negedge clk_i);
    model(en, skip);
    compare(tag);
  endtask

  initial begin
    @(negedge clk_i);
    model('0, '0);
    compare("R1");
    sig_en_i = '1; pin_skip_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    model('0, '0);
    compare("R1");
    rst_ni = 1'b1;
    sig_en_i = '0;
    @(negedge clk_i);
    model('0, '0);
    compare("R1");

    step("R4", 13'h1FFF, 8'h00);
    step("R5", 13'h1FFF, 8'h44);
    step("R2", 13'h0003, 8'h30);
    step("R3", 13'h1FFC, 8'h00);
    step("R3", 13'h0FFD, 8'h00);
    step("R7", 13'h0A54, 8'h00);
    step("R8", 13'h1FFC, 8'hF0);
    step("R8", 13'h1FFF, 8'hFF);
    step("R5", 13'h1FFC, 8'hFF);
    step("R6", 13'h1000, 8'h7F);
    step("R7", 13'h0000, 8'hA5);
    step("R4", 13'h1FFE, 8'h81);

    for (int n = 0; n < 400; n++) begin
      logic [NS-1:0] e;
      logic [NP-1:0] k;
      e = NS'($urandom());
      k = NP'($urandom()) & NP'($urandom());
      step("R4", e, k);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule